// File: doc/BRIEF.md
# Branch target cache

This block is a small direct-mapped cache that the instruction fetch stage consults with the current fetch address. When the address belongs to a branch seen before, the block reports a hit together with the remembered destination and a few bits of history in the same cycle. The fetch unit can then steer the next fetch toward the destination before the instruction is even decoded. A hit avoids the two-cycle fallback penalty only when the prediction is also correct. Prediction policy lives outside; this block only stores and returns the history field.

When a branch resolves later in the pipeline, the update port writes the branch address, its destination and the new history into the slot that the address selects. The slot is chosen by address bits just above the instruction alignment bits. The remaining upper bits are kept as a tag. Two branches whose slot bits agree compete for one slot, and the later write evicts the earlier one.

Top module: `branch_target_cache`

## Requirements
- R1: In the same cycle as the fetch address is presented, the lookup reports a hit when the selected slot is valid and its stored tag equals the fetch address tag. On a hit it returns that slot's target and history.
- R2: An active-low asynchronous reset invalidates every slot, so every lookup misses until a slot is written.
- R3: On a miss, the target and history outputs are all zeros.
- R4: With the update enable high at a rising clock edge, the slot picked by update address bits [OFF_W +: IDX_W] takes the tag (bits above those), target and history. The slot becomes valid, and a lookup of that branch hits from the next cycle on.
- R5: An update always overwrites its slot, whatever the slot held. A branch that previously lived in the slot with a different tag misses afterwards.
- R6: When a lookup and an update select the same slot in one cycle, the lookup returns the contents from before the update.
- R7: The lowest OFF_W address bits take no part in index or tag, so fetch addresses that differ only there give identical results.
- R8: With the update enable low, the update address, target and history inputs leave the stored contents unchanged.
- R9: Rewriting a branch that already hits replaces its target and history with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_pc_i | input | ADDR_W | Fetch address to look up |
| lkp_hit_o | output | 1 | Lookup found a valid slot with a matching tag |
| lkp_target_o | output | ADDR_W | Stored target on a hit, zero otherwise |
| lkp_hist_o | output | HIST_W | Stored history on a hit, zero otherwise |
| upd_en_i | input | 1 | Write the update fields at the next rising edge |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_target_i | input | ADDR_W | Target of the resolved branch |
| upd_hist_i | input | HIST_W | New history for the branch |

## Verification
A corrupted valid bit, tag, or slot selection shows up as a wrong hit flag in the very first lookup of the affected address. No latency hides it, because the read path is combinational. A target or history slip appears on the same lookup as a wrong value beside a correct hit. A write-path fault, such as a write to the wrong slot, an early write, or a write with the enable low, shows one cycle after the update. The reference model catches it on the next lookup of either the intended or the disturbed slot. Aliased addresses drawn from a small tag range make such disturbances frequent.

// File: rtl/btac_pkg.sv
package btac_pkg;
  localparam int DEF_ADDR_W = 32;
  localparam int DEF_IDX_W  = 4;
  localparam int DEF_HIST_W = 2;
  localparam int DEF_OFF_W  = 2;
endpackage

// File: rtl/btac_addr_split.sv
module btac_addr_split #(
  parameter int ADDR_W = btac_pkg::DEF_ADDR_W,
  parameter int IDX_W  = btac_pkg::DEF_IDX_W,
  parameter int OFF_W  = btac_pkg::DEF_OFF_W,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic unused_off;
  assign unused_off = ^pc_i[OFF_W-1:0];
  assign idx_o = pc_i[OFF_W +: IDX_W];
  assign tag_o = pc_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/btac_store.sv
module btac_store #(
  parameter int IDX_W  = btac_pkg::DEF_IDX_W,
  parameter int TAG_W  = 26,
  parameter int ADDR_W = btac_pkg::DEF_ADDR_W,
  parameter int HIST_W = btac_pkg::DEF_HIST_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_target_i,
  input  logic [HIST_W-1:0] wr_hist_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [ADDR_W-1:0] rd_target_o,
  output logic [HIST_W-1:0] rd_hist_o
);
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  we;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [ADDR_W-1:0] tgt_q  [DEPTH];
  logic [HIST_W-1:0] hist_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_we
    assign we[e] = wr_en_i && (wr_idx_i == IDX_W'(e));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        tag_q[e]  <= '0;
        tgt_q[e]  <= '0;
        hist_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (we[e]) begin
          valid_q[e] <= 1'b1;
          tag_q[e]   <= wr_tag_i;
          tgt_q[e]   <= wr_target_i;
          hist_q[e]  <= wr_hist_i;
        end
      end
    end
  end

  // read sees pre-edge contents: old data on same-slot collision
  assign rd_valid_o  = valid_q[rd_idx_i];
  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_target_o = tgt_q[rd_idx_i];
  assign rd_hist_o   = hist_q[rd_idx_i];
endmodule

// File: rtl/btac_match.sv
module btac_match #(
  parameter int TAG_W  = 26,
  parameter int ADDR_W = btac_pkg::DEF_ADDR_W,
  parameter int HIST_W = btac_pkg::DEF_HIST_W
) (
  input  logic              valid_i,
  input  logic [TAG_W-1:0]  stored_tag_i,
  input  logic [TAG_W-1:0]  fetch_tag_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [HIST_W-1:0] hist_o
);
  always_comb begin
    hit_o    = valid_i && (stored_tag_i == fetch_tag_i);
    target_o = hit_o ? target_i : '0;
    hist_o   = hit_o ? hist_i : '0;
  end
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache #(
  parameter int ADDR_W = btac_pkg::DEF_ADDR_W,
  parameter int IDX_W  = btac_pkg::DEF_IDX_W,
  parameter int HIST_W = btac_pkg::DEF_HIST_W,
  parameter int OFF_W  = btac_pkg::DEF_OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lkp_pc_i,
  output logic              lkp_hit_o,
  output logic [ADDR_W-1:0] lkp_target_o,
  output logic [HIST_W-1:0] lkp_hist_o,
  input  logic              upd_en_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic [HIST_W-1:0] upd_hist_i
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  lkp_idx, upd_idx;
  logic [TAG_W-1:0]  lkp_tag, upd_tag, rd_tag;
  logic              rd_valid;
  logic [ADDR_W-1:0] rd_target;
  logic [HIST_W-1:0] rd_hist;

  btac_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_lkp (
    .pc_i(lkp_pc_i), .idx_o(lkp_idx), .tag_o(lkp_tag)
  );

  btac_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_upd (
    .pc_i(upd_pc_i), .idx_o(upd_idx), .tag_o(upd_tag)
  );

  btac_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (upd_en_i),
    .wr_idx_i    (upd_idx),
    .wr_tag_i    (upd_tag),
    .wr_target_i (upd_target_i),
    .wr_hist_i   (upd_hist_i),
    .rd_idx_i    (lkp_idx),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_target_o (rd_target),
    .rd_hist_o   (rd_hist)
  );

  btac_match #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_match (
    .valid_i      (rd_valid),
    .stored_tag_i (rd_tag),
    .fetch_tag_i  (lkp_tag),
    .target_i     (rd_target),
    .hist_i       (rd_hist),
    .hit_o        (lkp_hit_o),
    .target_o     (lkp_target_o),
    .hist_o       (lkp_hist_o)
  );
endmodule

// File: rtl/btac_checker.sv
module btac_checker #(
  parameter int ADDR_W = btac_pkg::DEF_ADDR_W,
  parameter int IDX_W  = btac_pkg::DEF_IDX_W,
  parameter int HIST_W = btac_pkg::DEF_HIST_W,
  parameter int OFF_W  = btac_pkg::DEF_OFF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] lkp_pc_i,
  input logic              lkp_hit_o,
  input logic [ADDR_W-1:0] lkp_target_o,
  input logic [HIST_W-1:0] lkp_hist_o,
  input logic              upd_en_i,
  input logic [ADDR_W-1:0] upd_pc_i,
  input logic [ADDR_W-1:0] upd_target_i,
  input logic [HIST_W-1:0] upd_hist_i
);
  localparam int SH = OFF_W + IDX_W;

  logic [ADDR_W-1:0] lkp_key, upd_key;
  logic [IDX_W-1:0]  lkp_slot, upd_slot;
  assign lkp_key  = lkp_pc_i >> OFF_W;
  assign upd_key  = upd_pc_i >> OFF_W;
  assign lkp_slot = lkp_key[IDX_W-1:0];
  assign upd_slot = upd_key[IDX_W-1:0];

  // R2: first cycle out of reset sees an empty table
  a_r2_empty_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !lkp_hit_o);

  // R3
  a_r3_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> (lkp_target_o == '0) && (lkp_hist_o == '0));

  // R4
  a_r4_update_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(upd_en_i) && (lkp_key == $past(upd_key)))
    |-> lkp_hit_o && (lkp_target_o == $past(upd_target_i)) && (lkp_hist_o == $past(upd_hist_i)));

  // R5
  a_r5_alias_evicts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(upd_en_i) && (lkp_slot == $past(upd_slot))
     && ((lkp_pc_i >> SH) != ($past(upd_pc_i) >> SH))) |-> !lkp_hit_o);

  // R6, R8: outputs change only after a write or a new fetch address
  a_r6_stable_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(upd_en_i) && $stable(lkp_pc_i))
    |-> $stable(lkp_hit_o) && $stable(lkp_target_o) && $stable(lkp_hist_o));
endmodule

bind branch_target_cache btac_checker #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/tb_branch_target_cache.sv
`timescale 1ns/1ps
module tb_branch_target_cache;
  localparam int AW    = 32;
  localparam int IW    = 4;
  localparam int HW    = 2;
  localparam int OW    = 2;
  localparam int DEPTH = 1 << IW;
  localparam int SH    = OW + IW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] lkp_pc = '0;
  logic          hit;
  logic [AW-1:0] tgt;
  logic [HW-1:0] hist;
  logic          upd_en = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic [AW-1:0] upd_tgt = '0;
  logic [HW-1:0] upd_hist = '0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  bit            m_v   [DEPTH];
  logic [AW-1:0] m_key [DEPTH];
  logic [AW-1:0] m_tgt [DEPTH];
  logic [HW-1:0] m_hist[DEPTH];

  always #2.5 clk = ~clk;

  branch_target_cache #(.ADDR_W(AW), .IDX_W(IW), .HIST_W(HW), .OFF_W(OW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_pc_i(lkp_pc), .lkp_hit_o(hit),
    .lkp_target_o(tgt), .lkp_hist_o(hist), .upd_en_i(upd_en),
    .upd_pc_i(upd_pc), .upd_target_i(upd_tgt), .upd_hist_i(upd_hist)
  );

  function automatic int slot_of(input logic [AW-1:0] pc);
    return int'((pc >> OW) % DEPTH);
  endfunction

  function automatic logic [AW-1:0] make_pc(input int t, input int s, input int o);
    return (AW'(t) << SH) | (AW'(s) << OW) | AW'(o);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
  endtask

  task automatic compare(input string req);
    int s;
    logic eh;
    logic [AW-1:0] et;
    logic [HW-1:0] ehs;
    s   = slot_of(lkp_pc);
    eh  = m_v[s] && (m_key[s] == (lkp_pc >> SH));
    et  = eh ? m_tgt[s] : '0;
    ehs = eh ? m_hist[s] : '0;
    tests++;
    if (hit !== eh || tgt !== et || hist !== ehs) begin
      fails++;
      $display("FAIL %s pc=%h: actual hit=%b tgt=%h hist=%h expected hit=%b tgt=%h hist=%h",
               req, lkp_pc, hit, tgt, hist, eh, et, ehs);
    end
  endtask

  task automatic step(input logic [AW-1:0] lpc, input logic ue, input logic [AW-1:0] upc,
                      input logic [AW-1:0] ut, input logic [HW-1:0] uh, input string req);
    @(negedge clk);
    lkp_pc = lpc; upd_en = ue; upd_pc = upc; upd_tgt = ut; upd_hist = uh;
    #1;
    compare(req);
    @(posedge clk);
    if (ue) begin
      m_v[slot_of(upc)]    = 1'b1;
      m_key[slot_of(upc)]  = upc >> SH;
      m_tgt[slot_of(upc)]  = ut;
      m_hist[slot_of(upc)] = uh;
    end
  endtask

  task automatic look(input logic [AW-1:0] lpc, input string req);
    step(lpc, 1'b0, '0, '0, '0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pa, pb;
    model_clear();
    repeat (3) @(negedge clk);
    #1;
    compare("R2 in reset");
    rst_ni = 1'b1;
    pa = make_pc(5, 3, 0);
    pb = make_pc(9, 3, 0);

    // R2: empty after reset
    for (int i = 0; i < 6; i++) look(make_pc(i, i * 3 % DEPTH, 0), "R2");
    // R8: update fields with enable low
    step(pa, 1'b0, pa, 32'h1000_0040, 2'd3, "R8");
    look(pa, "R8");
    // R6 then R4: same-slot collision returns old, then visible
    step(pa, 1'b1, pa, 32'h1000_0040, 2'd2, "R6");
    look(pa, "R4");
    // R7: offset bits ignored
    look(pa | AW'(1), "R7");
    look(pa | AW'(3), "R7");
    // R6/R9: overwrite existing branch, same-cycle lookup still old
    step(pa, 1'b1, pa, 32'h2000_0080, 2'd1, "R6");
    look(pa, "R9");
    // R5: alias evicts
    step(pb, 1'b1, pb, 32'h3000_00c0, 2'd3, "R5");
    look(pa, "R5");
    look(pb, "R5");
    // R1: fill all slots, read back
    for (int s = 0; s < DEPTH; s++)
      step(make_pc(s + 1, (s + 3) % DEPTH, 0), 1'b1, make_pc(s + 1, s, 0),
           AW'(32'h4000_0000 + s * 4), HW'(s), "R1");
    for (int s = 0; s < DEPTH; s++) look(make_pc(s + 1, s, 2), "R1");
    // mixed traffic with heavy aliasing
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] lp, up;
      lp = make_pc(int'($urandom % 4), int'($urandom % DEPTH), int'($urandom % 4));
      up = make_pc(int'($urandom % 4), int'($urandom % DEPTH), int'($urandom % 4));
      if (i % 5 == 0) up = lp;
      step(lp, 1'($urandom % 2), up, AW'($urandom), HW'($urandom), "R1");
    end
    // R2: reset mid-run clears everything
    @(negedge clk);
    rst_ni = 1'b0; upd_en = 1'b0;
    model_clear();
    #1;
    compare("R2 mid-run");
    @(negedge clk);
    rst_ni = 1'b1;
    for (int s = 0; s < DEPTH; s++) look(make_pc(s % 4, s, 0), "R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule